// File: doc/BRIEF.md
# Byte-wide SPI master with register interface

This block is a single-channel SPI master that firmware drives through three small registers on a simple peripheral bus. Writing a byte to the data register launches one 8-bit full-duplex exchange: the byte leaves on MOSI most significant bit first, while eight bits are collected from MISO. A status register shows whether a byte is in flight and whether a received byte is waiting. A one-byte receive buffer holds that byte until firmware reads the data register.

A control register holds the enable bit, two clock-mode bits and a 7-bit divider. One mode bit sets the idle level of SCLK. The other selects the sampling edge. The divider sets the SCLK rate as a fraction of the bus clock. Chip select is not part of the block; an external general-purpose pin drives it. Bus reads are combinational on the address. Writes and read side effects take effect on the rising clock edge where the strobe is high.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the data register reads 0 and SCLK is low.
- R2: The control register sits at byte offset 2. Bit 0 is enable, bit 7 selects the alternate sampling edge (CPHA), bit 8 sets the SCLK idle level (CPOL), and bits 15:9 hold the divider (0 to 127). All other bits read 0. The status register sits at offset 4, with busy in bit 0 and receive-full in bit 1. The data register sits at offset 0 and uses bits 7:0.
- R3: A data-register write while the block is enabled and idle starts one exchange. Busy then reads 1 for exactly 16 x (divider + 1) bus cycles, starting at the clock edge that takes the write. Each SCLK half-period is divider + 1 bus cycles, up to the largest divider of 127.
- R4: MOSI carries the written byte most significant bit first. The received byte is the eight MISO bits, first bit most significant, each taken on the sampling edge. Mode 0 has both mode bits clear; mode 1 sets bit 7 only; mode 2 sets bit 8 only; mode 3 sets both. With bit 7 clear, sampling is on the edge that leaves the idle level. With bit 7 set, sampling is on the edge that returns to it.
- R5: When no exchange is running, SCLK sits at the level given by control bit 8. Each exchange makes exactly 16 SCLK transitions.
- R6: Receive-full sets when an exchange ends and stays set until the data register is read. That read returns the received byte and clears receive-full.
- R7: A data-register write while busy changes neither the byte being shifted nor the exchange length, and queues no second exchange.
- R8: Clearing enable stops a running exchange. One cycle after the enable bit is clear, busy and receive-full read 0 and SCLK is back at its idle level. A data write while disabled starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs all four clock modes against a modelled slave and compares both directions bit for bit. A design that samples on the wrong edge returns a byte shifted by one position, and one that moves MOSI too early corrupts the slave's copy. It times busy at dividers 0, 3 and 127: an off-by-one in the half-period counter, or in the edge count, gives the wrong number of cycles. It also writes to the data register mid-exchange and after disabling the block. A design that accepts these writes either corrupts the shifted byte or starts a stray exchange that leaves SCLK toggling. A design that does not clear state on disable leaves receive-full set or SCLK stuck at its active level.

// File: rtl/spi_byte_pkg.sv
// Shared constants and the control-word layout for the byte SPI master.
// Assumes a fixed 16-bit control word whose field positions firmware decodes.
package spi_byte_pkg;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned DIV_W      = 7;
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_PHA    = 7;
    localparam int unsigned BIT_POL    = 8;
    localparam int unsigned DIV_LSB    = 9;
    localparam int unsigned BIT_BUSY   = 0;
    localparam int unsigned BIT_FULL   = 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             pol;
        logic             pha;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/spi_byte_clkdiv.sv
// Half-period timer: emits a one-cycle tick every div+1 cycles while run is high.
// Assumes div is stable during an exchange; the count restarts whenever run drops.
module spi_byte_clkdiv #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count bus cycles within the current SCLK half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_byte_shift.sv
// Shift engine: runs 2*DATA_W SCLK half-periods per exchange, shifts out MSB
// first and collects MISO on the sampling edge chosen by cpha.
// Assumes start is asserted only when idle and enabled; en low aborts at once.
module spi_byte_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpha,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              phase,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int unsigned EDGES = 2 * DATA_W;
    localparam int unsigned IDX_W = $clog2(EDGES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(EDGES - 1);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh_tx;
    logic [DATA_W-1:0] sh_rx;
    logic              lead_edge;
    logic              sample_edge;
    logic              shift_edge;

    // Classify the coming edge: leading edges have even index.
    always_comb begin
        lead_edge   = ~idx[0];
        sample_edge = lead_edge ^ cpha;
        shift_edge  = ~sample_edge && !(cpha && idx == '0);
    end

    assign mosi    = sh_tx[DATA_W-1];
    assign done    = en && busy && tick && (idx == LAST);
    assign rx_byte = (tick && sample_edge) ? {sh_rx[DATA_W-2:0], miso} : sh_rx;

    // Sequence the exchange and move the shift registers on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            idx   <= '0;
            sh_tx <= '0;
            sh_rx <= '0;
        end else if (!en) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            idx   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            phase <= 1'b0;
            idx   <= '0;
            sh_tx <= tx_byte;
        end else if (busy && tick) begin
            phase <= ~phase;
            idx   <= idx + 1'b1;
            if (sample_edge) begin
                sh_rx <= {sh_rx[DATA_W-2:0], miso};
            end
            if (shift_edge) begin
                sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
            end
            if (idx == LAST) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_byte_regs.sv
// Register file: decodes bus accesses, holds the control word, the one-byte
// receive buffer and its full flag, and drives read data combinationally.
// Assumes single-cycle strobes; a data read clears the full flag at the edge.
module spi_byte_regs
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_byte,
    output ctrl_t             ctrl,
    output logic              wr_data,
    output logic              rd_data,
    output logic              rbf
);
    logic              wr_ctrl;
    logic [DATA_W-1:0] rx_buf;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign rd_data = bus_rd && (bus_addr == OFS_DATA);

    // Capture the control fields from their fixed bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.en  <= bus_wdata[BIT_EN];
            ctrl.pha <= bus_wdata[BIT_PHA];
            ctrl.pol <= bus_wdata[BIT_POL];
            ctrl.div <= bus_wdata[DIV_LSB +: DIV_W];
        end
    end

    // Hold the last received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
        end else if (xfer_done) begin
            rx_buf <= rx_byte;
        end
    end

    // Track the receive-full flag: set on completion, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.en) begin
            rbf <= 1'b0;
        end else if (xfer_done) begin
            rbf <= 1'b1;
        end else if (rd_data) begin
            rbf <= 1'b0;
        end
    end

    // Select read data by offset.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA: bus_rdata[DATA_W-1:0] = rx_buf;
            OFS_CTRL: begin
                bus_rdata[BIT_EN]               = ctrl.en;
                bus_rdata[BIT_PHA]              = ctrl.pha;
                bus_rdata[BIT_POL]              = ctrl.pol;
                bus_rdata[DIV_LSB +: DIV_W]     = ctrl.div;
            end
            OFS_STAT: begin
                bus_rdata[BIT_BUSY] = busy;
                bus_rdata[BIT_FULL] = rbf;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_byte_master.sv
// Top level of the byte SPI master: joins the register file, half-period
// timer and shift engine. Assumes chip select is handled outside the block.
module spi_byte_master
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    ctrl_t             ctrl;
    logic              ctrl_en;
    logic              ctrl_pol;
    logic              wr_data;
    logic              rd_data;
    logic              rbf;
    logic              busy;
    logic              phase;
    logic              tick;
    logic              xfer_done;
    logic              start;
    logic [DATA_W-1:0] rx_byte;

    assign ctrl_en  = ctrl.en;
    assign ctrl_pol = ctrl.pol;
    assign start    = wr_data && ctrl.en && !busy;
    assign sclk     = ctrl.pol ^ phase;

    spi_byte_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rbf       (rbf)
    );

    spi_byte_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (ctrl.div),
        .tick  (tick)
    );

    spi_byte_shift #(.DATA_W(DATA_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .cpha    (ctrl.pha),
        .start   (start),
        .tx_byte (bus_wdata[DATA_W-1:0]),
        .tick    (tick),
        .miso    (miso),
        .busy    (busy),
        .phase   (phase),
        .mosi    (mosi),
        .done    (xfer_done),
        .rx_byte (rx_byte)
    );
endmodule

// File: rtl/spi_byte_master_chk.sv
// Property checker for the byte SPI master, attached to the top by bind.
// Assumes it sees the top's enable, polarity, busy and flag signals.
module spi_byte_master_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic busy,
    input logic rbf,
    input logic sclk,
    input logic wr_data,
    input logic rd_data
);
    assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    assert_disable_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rbf);

    assert_sclk_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    assert_full_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && en) |-> rbf);

    assert_read_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !busy && en) |=> !rbf);

    assert_start_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_data && en));
endmodule

bind spi_byte_master spi_byte_master_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_en),
    .cpol    (ctrl_pol),
    .busy    (busy),
    .rbf     (rbf),
    .sclk    (sclk),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
// Directed bench for the byte SPI master with a modelled SPI slave.
module spi_byte_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Slave model state
    bit         armed = 0;
    logic       m_cpol = 0;
    logic       m_cpha = 0;
    logic [7:0] slv_tx = 8'h00;
    logic [7:0] slv_rx = 8'h00;
    int         slv_idx = 7;
    bit         slv_first = 1;
    int         sclk_edges = 0;

    always #2 clk = ~clk;

    spi_byte_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    assign miso = (slv_idx >= 0 && slv_idx < 8) ? slv_tx[slv_idx[2:0]] : 1'b0;

    // Slave: sample MOSI on the sampling edge, move MISO on the other edge.
    always @(sclk) begin
        if (armed) begin
            sclk_edges++;
            if (sclk != m_cpol) begin
                if (!m_cpha) slv_rx = {slv_rx[6:0], mosi};
                else begin
                    if (!slv_first) slv_idx--;
                    slv_first = 0;
                end
            end else begin
                if (m_cpha) slv_rx = {slv_rx[6:0], mosi};
                else slv_idx--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input int div, input bit pol, input bit pha,
                                              input bit en);
        return 16'((div << 9) | (int'(pol) << 8) | (int'(pha) << 7) | int'(en));
    endfunction

    task automatic arm(input logic [7:0] stx, input bit pol, input bit pha);
        m_cpol = pol; m_cpha = pha; slv_tx = stx; slv_rx = 8'h00;
        slv_idx = 7; slv_first = 1; sclk_edges = 0;
        @(negedge clk);
        armed = 1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd2, v); check(v == 16'h0, "R1", "ctrl after reset", v, 0);
        rd(3'd4, v); check(v == 16'h0, "R1", "status after reset", v, 0);
        rd(3'd0, v); check(v == 16'h0, "R1", "data after reset", v, 0);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    endtask

    task automatic t_ctrl_map();
        logic [15:0] v;
        wr(3'd2, 16'hFFFF);
        rd(3'd2, v); check(v == 16'hFF81, "R2", "ctrl readback all ones", v, 16'hFF81);
        wr(3'd2, 16'h5A7E);
        rd(3'd2, v); check(v == 16'h5A00, "R2", "ctrl readback pattern", v, 16'h5A00);
        wr(3'd2, 16'h0000);
    endtask

    // Full exchange in one mode; checks both directions, length and flags.
    task automatic t_xfer(input int div, input bit pol, input bit pha,
                          input logic [7:0] tx, input logic [7:0] stx);
        logic [15:0] v;
        int cyc;
        wr(3'd2, ctrl_word(div, pol, pha, 1'b1));
        @(negedge clk);
        check(sclk == pol, "R5", "idle sclk level", sclk, pol);
        arm(stx, pol, pha);
        wr(3'd0, {8'h00, tx});
        cyc = 0;
        bus_addr = 3'd4;
        forever begin
            #1;
            if (bus_rdata[0] !== 1'b1) break;
            cyc++;
            @(negedge clk);
        end
        armed = 0;
        check(cyc == 16 * (div + 1), "R3", "busy cycles", cyc, 16 * (div + 1));
        check(sclk_edges == 16, "R5", "sclk transitions", sclk_edges, 16);
        check(sclk == pol, "R5", "sclk back at idle", sclk, pol);
        check(slv_rx == tx, "R4", "byte seen on mosi", slv_rx, tx);
        rd(3'd4, v); check(v[1] == 1'b1, "R6", "full after exchange", v, 2);
        rd(3'd4, v); check(v[1] == 1'b1, "R6", "full held without data read", v, 2);
        rd(3'd0, v); check(v[7:0] == stx, "R4", "received byte", v[7:0], stx);
        rd(3'd4, v); check(v[1] == 1'b0, "R6", "full cleared by data read", v, 0);
    endtask

    task automatic t_busy_write();
        logic [15:0] v;
        wr(3'd2, ctrl_word(3, 1'b0, 1'b1, 1'b1));
        arm(8'h3C, 1'b0, 1'b1);
        wr(3'd0, 16'h00A5);
        repeat (20) @(negedge clk);
        wr(3'd0, 16'h00FF);
        bus_addr = 3'd4;
        forever begin
            #1;
            if (bus_rdata[0] !== 1'b1) break;
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        armed = 0;
        check(slv_rx == 8'hA5, "R7", "mosi byte unchanged by busy write", slv_rx, 8'hA5);
        check(sclk_edges == 16, "R7", "no second exchange", sclk_edges, 16);
        rd(3'd0, v); check(v[7:0] == 8'h3C, "R7", "received byte", v[7:0], 8'h3C);
        rd(3'd4, v); check(v == 16'h0, "R7", "status idle afterwards", v, 0);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        wr(3'd2, ctrl_word(2, 1'b1, 1'b0, 1'b1));
        arm(8'h81, 1'b1, 1'b0);
        wr(3'd0, 16'h0042);
        repeat (10) @(negedge clk);
        armed = 0;
        wr(3'd2, ctrl_word(2, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        rd(3'd4, v); check(v == 16'h0, "R8", "status after disable", v, 0);
        check(sclk == 1'b1, "R8", "sclk idle after disable", sclk, 1);
        arm(8'h00, 1'b1, 1'b0);
        wr(3'd0, 16'h00C3);
        repeat (40) @(negedge clk);
        armed = 0;
        rd(3'd4, v); check(v == 16'h0, "R8", "no exchange while disabled", v, 0);
        check(sclk_edges == 0, "R8", "sclk quiet while disabled", sclk_edges, 0);
        wr(3'd2, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_map();
        t_xfer(0, 1'b0, 1'b0, 8'hA5, 8'h5A);
        t_xfer(3, 1'b0, 1'b1, 8'h81, 8'h7E);
        t_xfer(1, 1'b1, 1'b0, 8'h00, 8'hC3);
        t_xfer(2, 1'b1, 1'b1, 8'hF0, 8'h0F);
        t_xfer(127, 1'b0, 1'b0, 8'h96, 8'h69);
        t_busy_write();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule